// File: doc/BRIEF.md
# Bus-Attached Multiply-Accumulate Unit

This block is a multiplier peripheral that sits on the word-wide register port of a 16-bit processor. Software selects a 16x16 operation by choosing which of four first-operand addresses it writes: unsigned multiply, signed multiply, unsigned multiply-accumulate or signed multiply-accumulate. Writing the second operand then computes the result in the same clock. Software reads the 32-bit result back as two words and reads a sign-extension word whose meaning depends on the mode.

A separate 32x32 path takes each 32-bit operand as a low word followed by a high word. Writing the high word of the second operand produces a 64-bit product, signed or unsigned. The product is read back as four words. Software can also preload the accumulator by writing the low result word. The value written is then zero- or sign-extended according to the current mode. Read data is registered: it appears one clock after the read strobe and is zero in every cycle without a read.

Top module: `mac_bus_unit`

## Requirements
- R1: After reset, every result word, extension word and wide-product word reads 0x0000, and the mode is unsigned multiply, so a low-result write of 0x8000 reads back a high word of 0x0000.
- R2: Writing operand 1 at 0x130 selects unsigned multiply. Writing operand 2 at 0x138 then stores the zero-extended 32-bit product, readable as a low word at 0x13A and a high word at 0x13C. In this mode the extension word at 0x13E reads 0x0000.
- R3: Writing operand 1 at 0x132 selects signed multiply. Both operands are sign-extended before the product is formed. The extension word reads 0xFFFF when bit 31 of the result is set and 0x0000 when it is clear.
- R4: A plain multiply (unsigned or signed) clears the accumulator, so the next multiply-accumulate result equals only its own product.
- R5: Writing operand 1 at 0x134 selects unsigned multiply-accumulate. Each operand-2 write adds the unsigned product to the accumulator modulo 2^32, and the new sum becomes the result. The extension word reads 0x0000 in this mode.
- R6: Writing operand 1 at 0x136 selects signed multiply-accumulate. Each operand-2 write adds the signed product modulo 2^32. The extension word reads 0xFFFF when bit 31 of the accumulator is set, and 0x0000 otherwise.
- R7: Writing the low result word at 0x13A loads both the result and the accumulator with that value. In the unsigned modes the value is zero-extended; in the signed modes it is sign-extended.
- R8: An operand-1 write leaves the result unchanged. Operand 1 and the mode persist, so repeated operand-2 writes reuse them.
- R9: The 32x32 path works as follows. Operand 1 low goes to 0x140 (selects unsigned) or 0x142 (selects signed). Operand 1 high goes to 0x144. Operand 2 low goes to 0x148 and operand 2 high goes to 0x14A. The high write of operand 2 stores the 64-bit product, which reads as words at 0x150, 0x152, 0x154 and 0x156, from least to most significant.
- R10: A low-word write of either 32-bit operand clears that operand's high half and leaves the 64-bit product unchanged.
- R11: Reads of operand addresses, unused addresses in the window 0x130 to 0x15B, and any address outside it return 0x0000. Writes outside the window change nothing.
- R12: Read data appears in the cycle after the read strobe. It is 0x0000 in any cycle that follows a cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address of the word access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Registered read data |

## Verification
Each 16x16 mode is swept over every pair drawn from a set of corner operands: zero, one, two, the largest positive value, the most negative value, all ones and two mixed patterns. This sweep separates zero from sign extension, and the all-ones and most-negative cases expose a missing or misplaced sign bit in both result words and in the extension word. The accumulate modes run the same sweep as one long chain, so carries across the word boundary and wrap-around modulo 2^32 are both exercised. The 32x32 path uses operands built from pairs of those corners in both signednesses. Targeted sequences cover accumulator clearing, preloading through the low result word, partial operand writes, and reads outside the decoded addresses.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int unsigned OFS_W = 6;

    typedef enum logic [1:0] {
        MD_UMUL = 2'd0,
        MD_SMUL = 2'd1,
        MD_UMAC = 2'd2,
        MD_SMAC = 2'd3
    } mac_mode_e;

    // word offsets from the window base
    localparam logic [OFS_W-1:0] OF_OP1_UMUL = 6'h00;
    localparam logic [OFS_W-1:0] OF_OP1_SMUL = 6'h02;
    localparam logic [OFS_W-1:0] OF_OP1_UMAC = 6'h04;
    localparam logic [OFS_W-1:0] OF_OP1_SMAC = 6'h06;
    localparam logic [OFS_W-1:0] OF_OP2      = 6'h08;
    localparam logic [OFS_W-1:0] OF_RES_LO   = 6'h0A;
    localparam logic [OFS_W-1:0] OF_RES_HI   = 6'h0C;
    localparam logic [OFS_W-1:0] OF_EXT      = 6'h0E;
    localparam logic [OFS_W-1:0] OF_W1_LO_U  = 6'h10;
    localparam logic [OFS_W-1:0] OF_W1_LO_S  = 6'h12;
    localparam logic [OFS_W-1:0] OF_W1_HI    = 6'h14;
    localparam logic [OFS_W-1:0] OF_W2_LO    = 6'h18;
    localparam logic [OFS_W-1:0] OF_W2_HI    = 6'h1A;
    localparam logic [OFS_W-1:0] OF_WRES0    = 6'h20;
    localparam logic [OFS_W-1:0] OF_WRES1    = 6'h22;
    localparam logic [OFS_W-1:0] OF_WRES2    = 6'h24;
    localparam logic [OFS_W-1:0] OF_WRES3    = 6'h26;
    localparam logic [OFS_W-1:0] OF_LAST     = 6'h2B;

    function automatic logic mode_signed(input mac_mode_e m);
        return (m == MD_SMUL) || (m == MD_SMAC);
    endfunction

    function automatic logic mode_accum(input mac_mode_e m);
        return (m == MD_UMAC) || (m == MD_SMAC);
    endfunction

endpackage

// File: rtl/mac_addr_dec.sv
module mac_addr_dec #(
    parameter int unsigned AW   = 16,
    parameter int unsigned BASE = 16'h0130
) (
    input  logic [AW-1:0]              addr,
    output logic                       in_win,
    output logic [mac_pkg::OFS_W-1:0]  ofs
);
    import mac_pkg::*;

    localparam logic [AW-1:0] LO_ADDR = AW'(BASE);
    localparam logic [AW-1:0] HI_ADDR = AW'(BASE + int'(OF_LAST));

    logic [AW-1:0] diff;

    always_comb begin
        diff   = addr - LO_ADDR;
        in_win = (addr >= LO_ADDR) && (addr <= HI_ADDR);
        ofs    = in_win ? diff[OFS_W-1:0] : '0;
    end

endmodule

// File: rtl/mac_mult_core.sv
module mac_mult_core #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           sgn,
    output logic [2*W-1:0] prod
);
    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] a_x;
    logic [PW-1:0] b_x;

    // extend to full product width; the low PW bits of the product are
    // then correct for both signed and unsigned operands
    always_comb begin
        a_x  = {{W{sgn & a[W-1]}}, a};
        b_x  = {{W{sgn & b[W-1]}}, b};
        prod = a_x * b_x;
    end

endmodule

// File: rtl/mac_bus_unit.sv
module mac_bus_unit #(
    parameter int unsigned AW   = 16,
    parameter int unsigned DW   = 16,
    parameter int unsigned BASE = 16'h0130
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata
);
    import mac_pkg::*;

    localparam int unsigned PW = 2 * DW;
    localparam int unsigned QW = 4 * DW;

    typedef struct packed {
        mac_mode_e     mode;
        logic [DW-1:0] op1;
        logic [PW-1:0] acc;
        logic [PW-1:0] res;
        logic          w_sgn;
        logic [PW-1:0] w_op1;
        logic [PW-1:0] w_op2;
        logic [QW-1:0] w_res;
        logic [DW-1:0] rdata;
    } st_t;

    st_t st_d, st_q;

    logic             in_win;
    logic [OFS_W-1:0] ofs;
    logic             wr_hit, rd_hit;
    logic [PW-1:0]    prod16;
    logic [QW-1:0]    prod32;
    logic [PW-1:0]    w_op2_full;
    logic [DW-1:0]    rd_mux;

    mac_addr_dec #(.AW(AW), .BASE(BASE)) u_dec (
        .addr   (bus_addr),
        .in_win (in_win),
        .ofs    (ofs)
    );

    assign wr_hit     = bus_wr & in_win;
    assign rd_hit     = bus_rd & in_win;
    assign w_op2_full = {bus_wdata, st_q.w_op2[DW-1:0]};

    mac_mult_core #(.W(DW)) u_mul16 (
        .a    (st_q.op1),
        .b    (bus_wdata),
        .sgn  (mode_signed(st_q.mode)),
        .prod (prod16)
    );

    mac_mult_core #(.W(PW)) u_mul32 (
        .a    (st_q.w_op1),
        .b    (w_op2_full),
        .sgn  (st_q.w_sgn),
        .prod (prod32)
    );

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        unique case (ofs)
            OF_RES_LO: rd_mux = st_q.res[DW-1:0];
            OF_RES_HI: rd_mux = st_q.res[PW-1:DW];
            OF_EXT: begin
                if (st_q.mode == MD_SMUL)      rd_mux = {DW{st_q.res[PW-1]}};
                else if (st_q.mode == MD_SMAC) rd_mux = {DW{st_q.acc[PW-1]}};
                else                           rd_mux = '0;
            end
            OF_WRES0: rd_mux = st_q.w_res[DW-1:0];
            OF_WRES1: rd_mux = st_q.w_res[2*DW-1:DW];
            OF_WRES2: rd_mux = st_q.w_res[3*DW-1:2*DW];
            OF_WRES3: rd_mux = st_q.w_res[4*DW-1:3*DW];
            default:  rd_mux = '0;
        endcase
    end

    // next-state computation
    always_comb begin
        st_d       = st_q;
        st_d.rdata = rd_hit ? rd_mux : '0;
        if (wr_hit) begin
            unique case (ofs)
                OF_OP1_UMUL: begin st_d.op1 = bus_wdata; st_d.mode = MD_UMUL; end
                OF_OP1_SMUL: begin st_d.op1 = bus_wdata; st_d.mode = MD_SMUL; end
                OF_OP1_UMAC: begin st_d.op1 = bus_wdata; st_d.mode = MD_UMAC; end
                OF_OP1_SMAC: begin st_d.op1 = bus_wdata; st_d.mode = MD_SMAC; end
                OF_OP2: begin
                    if (mode_accum(st_q.mode)) begin
                        st_d.acc = st_q.acc + prod16;
                        st_d.res = st_q.acc + prod16;
                    end else begin
                        st_d.acc = '0;
                        st_d.res = prod16;
                    end
                end
                OF_RES_LO: begin
                    st_d.res = {{DW{mode_signed(st_q.mode) & bus_wdata[DW-1]}}, bus_wdata};
                    st_d.acc = {{DW{mode_signed(st_q.mode) & bus_wdata[DW-1]}}, bus_wdata};
                end
                OF_W1_LO_U: begin st_d.w_op1 = {{DW{1'b0}}, bus_wdata}; st_d.w_sgn = 1'b0; end
                OF_W1_LO_S: begin st_d.w_op1 = {{DW{1'b0}}, bus_wdata}; st_d.w_sgn = 1'b1; end
                OF_W1_HI:   st_d.w_op1 = {bus_wdata, st_q.w_op1[DW-1:0]};
                OF_W2_LO:   st_d.w_op2 = {{DW{1'b0}}, bus_wdata};
                OF_W2_HI: begin
                    st_d.w_op2 = w_op2_full;
                    st_d.w_res = prod32;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.mode  <= MD_UMUL;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

    // R12: no read strobe, no data
    p_rd_idle_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // R11: outside the window reads return zero
    p_out_window_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !in_win) |=> (bus_rdata == '0));

    // R4: plain multiply leaves the accumulator cleared
    p_mul_clears_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && ofs == OF_OP2 && !mode_accum(st_q.mode)) |=> (st_q.acc == '0));

    // R8: operand-1 writes do not touch the result
    p_op1_no_compute_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (ofs == OF_OP1_UMUL || ofs == OF_OP1_SMUL ||
                    ofs == OF_OP1_UMAC || ofs == OF_OP1_SMAC)) |=> $stable(st_q.res));

    // R10: low operand writes do not change the wide product
    p_wide_low_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (ofs == OF_W2_LO || ofs == OF_W1_LO_U || ofs == OF_W1_LO_S))
        |=> $stable(st_q.w_res));

    // R5: extension word is zero in the unsigned modes
    p_ext_unsigned_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && ofs == OF_EXT && !mode_signed(st_q.mode)) |=> (bus_rdata == '0));

endmodule

// File: tb/mac_bus_unit_tb.sv
module mac_bus_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mac_bus_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata)
    );

    logic [15:0] corner [8] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
                                16'h8000, 16'hFFFF, 16'h1234, 16'hA5A5};

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    function automatic logic [31:0] p16(input logic [15:0] a, input logic [15:0] b, input bit sg);
        longint sa, sb, p;
        sa = sg ? longint'($signed(a)) : longint'(a);
        sb = sg ? longint'($signed(b)) : longint'(b);
        p  = sa * sb;
        return p[31:0];
    endfunction

    function automatic logic [63:0] p32(input logic [31:0] a, input logic [31:0] b, input bit sg);
        longint p;
        if (sg) begin
            p = longint'($signed(a)) * longint'($signed(b));
            return p;
        end
        return {32'h0, a} * {32'h0, b};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] op1a [4] = '{16'h0130, 16'h0132, 16'h0134, 16'h0136};
        logic [31:0] acc, res;
        logic [15:0] v;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk("R1 res_lo", 16'h013A, 16'h0000);
        rd_chk("R1 res_hi", 16'h013C, 16'h0000);
        rd_chk("R1 ext", 16'h013E, 16'h0000);
        for (int k = 0; k < 4; k++) rd_chk("R1 wide", 16'h0150 + 16'(2 * k), 16'h0000);
        wr(16'h013A, 16'h8000);
        rd_chk("R1 default unsigned hi", 16'h013C, 16'h0000);

        // R2/R3: plain multiply sweeps
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    res = p16(corner[i], corner[j], m == 1);
                    wr(op1a[m], corner[i]);
                    wr(16'h0138, corner[j]);
                    rd_chk(m == 0 ? "R2 lo" : "R3 lo", 16'h013A, res[15:0]);
                    rd_chk(m == 0 ? "R2 hi" : "R3 hi", 16'h013C, res[31:16]);
                    rd_chk(m == 0 ? "R2 ext" : "R3 ext", 16'h013E,
                           (m == 1 && res[31]) ? 16'hFFFF : 16'h0000);
                end
            end
        end

        // R5/R6: accumulate chains
        for (int m = 2; m < 4; m++) begin
            wr(op1a[m], 16'h0000);
            wr(16'h013A, 16'h0000);
            acc = '0;
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    acc = acc + p16(corner[i], corner[j], m == 3);
                    wr(op1a[m], corner[i]);
                    wr(16'h0138, corner[j]);
                    rd_chk(m == 2 ? "R5 lo" : "R6 lo", 16'h013A, acc[15:0]);
                    rd_chk(m == 2 ? "R5 hi" : "R6 hi", 16'h013C, acc[31:16]);
                    rd_chk(m == 2 ? "R5 ext" : "R6 ext", 16'h013E,
                           (m == 3 && acc[31]) ? 16'hFFFF : 16'h0000);
                end
            end
        end

        // R4: plain multiply clears the accumulator
        wr(16'h0132, 16'h0003);
        wr(16'h0138, 16'h0005);
        wr(16'h0134, 16'h0007);
        wr(16'h0138, 16'h0002);
        rd_chk("R4 mac after mul lo", 16'h013A, 16'h000E);
        rd_chk("R4 mac after mul hi", 16'h013C, 16'h0000);

        // R8: op1 write keeps result; op2 reuse accumulates again
        wr(16'h0134, 16'h0100);
        rd_chk("R8 op1 no compute", 16'h013A, 16'h000E);
        wr(16'h0138, 16'h0001);
        wr(16'h0138, 16'h0001);
        rd_chk("R8 reuse op1", 16'h013A, 16'h020E);

        // R7: low-result preload, unsigned then signed
        wr(16'h0134, 16'h0002);
        wr(16'h013A, 16'h8000);
        rd_chk("R7 unsigned preload hi", 16'h013C, 16'h0000);
        wr(16'h0138, 16'h0003);
        rd_chk("R7 preload accumulate lo", 16'h013A, 16'h8006);
        rd_chk("R7 preload accumulate hi", 16'h013C, 16'h0000);
        wr(16'h0136, 16'h0001);
        wr(16'h013A, 16'h8000);
        rd_chk("R7 signed preload hi", 16'h013C, 16'hFFFF);
        rd_chk("R6 ext after preload", 16'h013E, 16'hFFFF);
        wr(16'h0138, 16'h7FFF);
        rd_chk("R7 signed preload accumulate hi", 16'h013C, 16'hFFFF);
        rd_chk("R7 signed preload accumulate lo", 16'h013A, 16'hFFFF);
        wr(16'h0132, 16'h0000);
        wr(16'h013A, 16'hFFFE);
        rd_chk("R3 ext after preload", 16'h013E, 16'hFFFF);

        // R9: wide product sweep
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    logic [31:0] a32, b32;
                    logic [63:0] q;
                    a32 = {corner[i], corner[7 - j]};
                    b32 = {corner[j], corner[(i + 3) % 8]};
                    q   = p32(a32, b32, s == 1);
                    wr(s == 1 ? 16'h0142 : 16'h0140, a32[15:0]);
                    wr(16'h0144, a32[31:16]);
                    wr(16'h0148, b32[15:0]);
                    wr(16'h014A, b32[31:16]);
                    rd_chk("R9 w0", 16'h0150, q[15:0]);
                    rd_chk("R9 w1", 16'h0152, q[31:16]);
                    rd_chk("R9 w2", 16'h0154, q[47:32]);
                    rd_chk("R9 w3", 16'h0156, q[63:48]);
                end
            end
        end

        // R10: low writes clear high half and hold the product
        wr(16'h0140, 16'h0003);
        wr(16'h0144, 16'h0001);
        wr(16'h0148, 16'h0002);
        wr(16'h014A, 16'h0000);
        rd_chk("R10 setup w0", 16'h0150, 16'h0006);
        rd_chk("R10 setup w1", 16'h0152, 16'h0002);
        wr(16'h0140, 16'h0005);
        rd_chk("R10 op1 low holds product", 16'h0150, 16'h0006);
        wr(16'h0148, 16'h0007);
        rd_chk("R10 op2 low holds product", 16'h0152, 16'h0002);
        wr(16'h014A, 16'h0000);
        rd_chk("R10 op1 high cleared w0", 16'h0150, 16'h0023);
        rd_chk("R10 op1 high cleared w1", 16'h0152, 16'h0000);

        // R11: unmapped reads and out-of-window writes
        wr(16'h0130, 16'h0004);
        wr(16'h0138, 16'h0004);
        rd_chk("R11 op1 addr", 16'h0130, 16'h0000);
        rd_chk("R11 op2 addr", 16'h0138, 16'h0000);
        rd_chk("R11 unused in window", 16'h015A, 16'h0000);
        rd_chk("R11 below window", 16'h012E, 16'h0000);
        rd_chk("R11 above window", 16'h015C, 16'h0000);
        wr(16'h0238, 16'h0009);
        wr(16'h0038, 16'h0009);
        rd_chk("R11 outside write ignored", 16'h013A, 16'h0010);

        // R12: idle cycle gives zero data
        rd(16'h013A, v);
        chk("R12 read data", v, 16'h0010);
        @(negedge clk);
        chk("R12 idle zero", bus_rdata, 16'h0000);

        finish_run();
    end

endmodule